// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This unit performs one 32-bit clamped arithmetic operation per start strobe. A 4-bit operation code picks signed add, signed subtract, signed doubling, unsigned add, unsigned subtract, a signed or unsigned range clamp set by a 5-bit width field, or a two-lane form of either range clamp that works on the two 16-bit halves of operand `a` independently. When an operation clamps, a sticky saturation flag is set. The flag stays set until the clear input is raised.

Control is a two-state machine. `ST_IDLE` waits for work. Any cycle with `start` high moves it to `ST_RESULT`, and the result register is loaded on that same edge. `ST_RESULT` returns to `ST_IDLE` when `start` is low and stays in `ST_RESULT` when `start` is high again. `done` is high exactly while the state is `ST_RESULT`, so back-to-back starts give one result per cycle.

Top module: `sat_alu`

## Requirements
- R1: After reset, `result` is 0, `done` is 0 and `sat_flag` is 0.
- R2: `result` and `done` appear in the cycle after a cycle with `start` high. `done` is low after any cycle with `start` low, and `result` holds its value when `start` is low.
- R3: Signed add (op 0) and signed subtract (op 1) saturate on two's-complement overflow. The result is 0x7FFFFFFF if `a` is non-negative and 0x80000000 if `a` is negative. Otherwise the result is the wrapped sum or difference.
- R4: Signed doubling (op 2) gives 0x7FFFFFFF with a clamp when signed `a` ≥ 0x40000000. It gives 0x80000000 with a clamp when signed `a` ≤ 0xC0000000. Otherwise it gives 2·`a`.
- R5: Unsigned add (op 3) gives 0xFFFFFFFF with a clamp on carry out. Unsigned subtract (op 4) gives 0 with a clamp when `b` > `a`. Otherwise each gives the plain sum or difference.
- R6: Signed clamp (op 5), with k = `sat_w`, limits signed `a` to the range [−2^k, 2^k−1]. A value outside the range takes the nearer bound and counts as a clamp.
- R7: Unsigned clamp (op 6), with k = `sat_w`, maps negative `a` to 0 and values above 2^k−1 to 2^k−1. Both cases count as a clamp.
- R8: The two-lane clamps apply the R6 rule (op 7) or the R7 rule (op 8) separately to sign-extended `a[15:0]` and `a[31:16]`. Each 16-bit lane result goes back into its own half. A clamp in either lane counts as a clamp.
- R9: `sat_flag` is set in the cycle after a started operation clamps. An operation that does not clamp leaves it unchanged.
- R10: A cycle with `clr_sat` high makes `sat_flag` 0 in the next cycle. This holds even when a clamping operation starts in the same cycle.
- R11: Op codes 9 to 15 give a result of 0 and never clamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation this cycle |
| op | input | 4 | Operation code (see R3–R11) |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| sat_w | input | 5 | Clamp width k for ops 5–8 |
| clr_sat | input | 1 | Clear the sticky saturation flag |
| result | output | 32 | Registered result |
| done | output | 1 | Result valid strobe |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench builds the unit with its default 32-bit width and 5-bit clamp width field. With these values the true extreme operands are reachable: 0x7FFFFFFF, 0x80000000 and the doubling limits 0x40000000 and 0xC0000000. Every clamp width from 0 to 31 is also reachable, including k = 0 (range −1..0) and k = 31 (nothing clamps in the single-lane signed clamp). With a 16-bit lane, widths of 15 and above make the two-lane signed clamp inert, and the bench visits that case along with the lane boundaries.

// File: rtl/sat_pkg.sv
package sat_pkg;
    typedef enum logic [3:0] {
        OP_SADD  = 4'd0,
        OP_SSUB  = 4'd1,
        OP_SDBL  = 4'd2,
        OP_UADD  = 4'd3,
        OP_USUB  = 4'd4,
        OP_SCLMP = 4'd5,
        OP_UCLMP = 4'd6,
        OP_SCLM2 = 4'd7,
        OP_UCLM2 = 4'd8
    } sat_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } sat_state_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         clamp
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   sum_x;
    logic [W:0]   dif_x;
    logic         ovf_add;
    logic         ovf_sub;
    logic         dbl_hi;
    logic         dbl_lo;
    logic [W-1:0] sgn_bound;

    always_comb begin
        sum_x     = {1'b0, a} + {1'b0, b};
        dif_x     = {1'b0, a} - {1'b0, b};
        ovf_add   = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
        ovf_sub   = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
        dbl_hi    = !a[W-1] && a[W-2];
        dbl_lo    = a[W-1] && (!a[W-2] || (a[W-3:0] == '0));
        sgn_bound = a[W-1] ? SMIN : SMAX;
        res       = '0;
        clamp     = 1'b0;
        case (op)
            OP_SADD: begin
                clamp = ovf_add;
                res   = ovf_add ? sgn_bound : sum_x[W-1:0];
            end
            OP_SSUB: begin
                clamp = ovf_sub;
                res   = ovf_sub ? sgn_bound : dif_x[W-1:0];
            end
            OP_SDBL: begin
                clamp = dbl_hi || dbl_lo;
                res   = dbl_hi ? SMAX : (dbl_lo ? SMIN : {a[W-2:0], 1'b0});
            end
            OP_UADD: begin
                clamp = sum_x[W];
                res   = sum_x[W] ? '1 : sum_x[W-1:0];
            end
            OP_USUB: begin
                clamp = dif_x[W];
                res   = dif_x[W] ? '0 : dif_x[W-1:0];
            end
            default: begin
                res   = '0;
                clamp = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int W  = 32,
    parameter int KW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [KW-1:0] k,
    input  logic          is_signed,
    output logic [W-1:0]  res,
    output logic          clamp
);
    logic [W-1:0] lim_hi;
    logic [W-1:0] lim_lo;
    logic         above;
    logic         below;

    always_comb begin
        lim_hi = (W'(1) << k) - W'(1);
        lim_lo = ~lim_hi;
        above  = $signed(val) > $signed(lim_hi);
        below  = is_signed ? ($signed(val) < $signed(lim_lo)) : val[W-1];
        clamp  = above || below;
        if (above)      res = lim_hi;
        else if (below) res = is_signed ? lim_lo : '0;
        else            res = val;
    end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_pkg::*;
#(
    parameter int W  = 32,
    parameter int KW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [KW-1:0] sat_w,
    input  logic          clr_sat,
    output logic [W-1:0]  result,
    output logic          done,
    output logic          sat_flag
);
    localparam int H  = W / 2;
    localparam int NC = 3;

    sat_state_e state_q, state_n;

    logic [W-1:0] as_res;
    logic         as_clamp;
    logic [W-1:0] cl_in  [NC];
    logic [W-1:0] cl_res [NC];
    logic         cl_hit [NC];
    logic         uns_sel;
    logic [W-1:0] res_n;
    logic         clamp_n;
    logic [W-1:0] result_q;
    logic         flag_q;

    sat_addsub #(.W(W)) u_addsub (
        .op   (op),
        .a    (a),
        .b    (b),
        .res  (as_res),
        .clamp(as_clamp)
    );

    assign uns_sel  = (op == OP_UCLMP) || (op == OP_UCLM2);
    assign cl_in[0] = a;
    assign cl_in[1] = {{H{a[H-1]}}, a[H-1:0]};
    assign cl_in[2] = {{H{a[W-1]}}, a[W-1:H]};

    for (genvar g = 0; g < NC; g++) begin : g_clamp
        sat_clamp #(.W(W), .KW(KW)) u_clamp (
            .val      (cl_in[g]),
            .k        (sat_w),
            .is_signed(!uns_sel),
            .res      (cl_res[g]),
            .clamp    (cl_hit[g])
        );
    end

    always_comb begin
        case (op)
            OP_SCLMP, OP_UCLMP: begin
                res_n   = cl_res[0];
                clamp_n = cl_hit[0];
            end
            OP_SCLM2, OP_UCLM2: begin
                res_n   = {cl_res[2][H-1:0], cl_res[1][H-1:0]};
                clamp_n = cl_hit[1] || cl_hit[2];
            end
            default: begin
                res_n   = as_res;
                clamp_n = as_clamp;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_n = start ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_n = start ? ST_RESULT : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (start) result_q <= res_n;
            if (clr_sat)                 flag_q <= 1'b0;
            else if (start && clamp_n)   flag_q <= 1'b1;
        end
    end

    assign result   = result_q;
    assign done     = (state_q == ST_RESULT);
    assign sat_flag = flag_q;
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
    parameter int W  = 32,
    parameter int KW = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [3:0]    op,
    input logic [W-1:0]  a,
    input logic [W-1:0]  b,
    input logic [KW-1:0] sat_w,
    input logic          clr_sat,
    input logic [W-1:0]  result,
    input logic          done,
    input logic          sat_flag
);
    a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    a_r2_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    a_r2_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));
    a_r5_uadd_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 4'd3) |=> (result >= $past(a)));
    a_r5_usub_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 4'd4) |=> (result <= $past(a)));
    a_r6_within_top: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 4'd5) |=>
            ($signed(result) <= $signed((W'(1) << $past(sat_w)) - W'(1))));
    a_r9_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(start));
    a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sat_flag) |-> $past(clr_sat));
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_sat |=> !sat_flag);
    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op >= 4'd9) |=> (result == '0));
endmodule

bind sat_alu sat_alu_chk #(.W(W), .KW(KW)) u_chk (.*);

// File: tb/tb_sat_alu.sv
`timescale 1ns/1ps
module tb_sat_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [4:0]  sat_w = '0;
    logic        clr_sat = 1'b0;
    logic [31:0] result;
    logic        done;
    logic        sat_flag;

    int checks = 0;
    int fails  = 0;
    bit exp_flag = 1'b0;

    always #10 clk = ~clk;

    sat_alu dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
        .sat_w(sat_w), .clr_sat(clr_sat), .result(result), .done(done),
        .sat_flag(sat_flag)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [32:0] fit_s32(longint r);
        if (r > 64'sd2147483647)       return {1'b1, 32'h7FFFFFFF};
        else if (r < -64'sd2147483648) return {1'b1, 32'h80000000};
        else                           return {1'b0, r[31:0]};
    endfunction

    function automatic logic [32:0] ref_s(longint v, int k);
        longint hi = (64'sd1 <<< k) - 1;
        longint lo = -(64'sd1 <<< k);
        if (v > hi)      return {1'b1, hi[31:0]};
        else if (v < lo) return {1'b1, lo[31:0]};
        else             return {1'b0, v[31:0]};
    endfunction

    function automatic logic [32:0] ref_u(longint v, int k);
        longint hi = (64'sd1 <<< k) - 1;
        if (v < 0)       return {1'b1, 32'h0};
        else if (v > hi) return {1'b1, hi[31:0]};
        else             return {1'b0, v[31:0]};
    endfunction

    function automatic logic [32:0] model(int o, logic [31:0] x, logic [31:0] y, int k);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint ux = longint'({32'h0, x});
        longint uy = longint'({32'h0, y});
        longint l0 = longint'($signed(x[15:0]));
        longint l1 = longint'($signed(x[31:16]));
        logic [32:0] p, q;
        case (o)
            0: return fit_s32(sx + sy);
            1: return fit_s32(sx - sy);
            2: begin
                if (sx >= 64'sd1073741824)  return {1'b1, 32'h7FFFFFFF};
                if (sx <= -64'sd1073741824) return {1'b1, 32'h80000000};
                return {1'b0, x[30:0], 1'b0};
            end
            3: return (ux + uy > 64'sd4294967295) ? {1'b1, 32'hFFFFFFFF} : {1'b0, x + y};
            4: return (uy > ux) ? {1'b1, 32'h0} : {1'b0, x - y};
            5: return ref_s(sx, k);
            6: return ref_u(sx, k);
            7, 8: begin
                p = (o == 7) ? ref_s(l0, k) : ref_u(l0, k);
                q = (o == 7) ? ref_s(l1, k) : ref_u(l1, k);
                return {p[32] | q[32], q[15:0], p[15:0]};
            end
            default: return {1'b0, 32'h0};
        endcase
    endfunction

    // one operation: drive at a falling edge, sample at the next falling edge
    task automatic run(string req, int o, logic [31:0] x, logic [31:0] y, int k, bit clr);
        logic [32:0] e;
        e = model(o, x, y, k);
        @(negedge clk);
        start = 1'b1; op = 4'(o); a = x; b = y; sat_w = 5'(k); clr_sat = clr;
        @(negedge clk);
        start = 1'b0; clr_sat = 1'b0;
        if (clr) exp_flag = 1'b0;
        else if (e[32]) exp_flag = 1'b1;
        chk(req, result, e[31:0]);
        chk({req, " done"}, {31'h0, done}, 32'h1);
        chk("R9 sticky", {31'h0, sat_flag}, {31'h0, exp_flag});
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 8)
            0: return 32'h7FFFFFFF;
            1: return 32'h80000000;
            2: return 32'h40000000 - ($urandom % 2);
            3: return 32'hC0000000 + ($urandom % 2);
            4: return $urandom % 300;
            5: return 32'hFFFFFF00 | ($urandom % 256);
            6: return {16'($urandom % 3) - 16'd1, 16'($urandom)};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 result", result, 32'h0);
        chk("R1 done", {31'h0, done}, 32'h0);
        chk("R1 flag", {31'h0, sat_flag}, 32'h0);
        rst_n = 1'b1;

        run("R11 reserved", 12, 32'h7FFFFFFF, 32'h1, 3, 0);
        run("R3 sadd pos", 0, 32'h7FFFFFFF, 32'h1, 0, 0);
        run("R10 clr+clamp", 0, 32'h7FFFFFFF, 32'h1, 0, 1);
        run("R3 sadd neg", 0, 32'h80000000, 32'hFFFFFFFF, 0, 0);
        run("R3 ssub neg", 1, 32'h80000000, 32'h1, 0, 0);
        run("R3 ssub pos", 1, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 0);
        run("R9 no-clamp keeps", 0, 32'h5, 32'h6, 0, 0);
        run("R10 clr", 0, 32'h5, 32'h6, 0, 1);
        run("R4 dbl at 0x3FFFFFFF", 2, 32'h3FFFFFFF, 32'h0, 0, 0);
        run("R4 dbl at 0x40000000", 2, 32'h40000000, 32'h0, 0, 1);
        run("R4 dbl at 0xC0000000", 2, 32'hC0000000, 32'h0, 0, 1);
        run("R4 dbl at 0xC0000001", 2, 32'hC0000001, 32'h0, 0, 1);
        run("R5 uadd carry", 3, 32'hFFFFFFFF, 32'h1, 0, 1);
        run("R5 usub borrow", 4, 32'h3, 32'h4, 0, 1);
        run("R6 ssat k7 hi", 5, 32'd200, 32'h0, 7, 1);
        run("R6 ssat k7 lo", 5, -32'sd200, 32'h0, 7, 1);
        run("R6 ssat k0", 5, 32'h1, 32'h0, 0, 1);
        run("R6 ssat k31", 5, 32'h80000000, 32'h0, 31, 1);
        run("R7 usat neg", 6, 32'hFFFFFFFE, 32'h0, 8, 1);
        run("R7 usat k8", 6, 32'd256, 32'h0, 8, 1);
        run("R8 dual s", 7, 32'h7FFF8000, 32'h0, 7, 1);
        run("R8 dual s k15", 7, 32'h7FFF8000, 32'h0, 15, 1);
        run("R8 dual u", 8, 32'h01008001, 32'h0, 8, 1);
        run("R8 dual u k20", 8, 32'hFFFF7FFF, 32'h0, 20, 1);

        // R2 done drops and result holds without start
        @(negedge clk);
        chk("R2 done low", {31'h0, done}, 32'h0);
        chk("R2 result held", result, model(8, 32'hFFFF7FFF, 32'h0, 20));

        for (int i = 0; i < 3000; i++) begin
            int o = $urandom % 16;
            run("R3-R11 random", (o > 9) ? ($urandom % 9) : o, pick(), pick(),
                $urandom % 32, ($urandom % 16) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule